// File: doc/BRIEF.md
# Ping-Pong Waveform DAC Player

The player streams 16-bit codes to a serial DAC over a three-wire link (active-low select, serial clock, serial data), one frame per conversion. A programmable divider sets the conversion rate from the system clock. Each frame carries one code from one of four sources. The first source is a waveform buffer loaded by a processor. The second is a stream memory written by the device under test. The third is a direct bypass word from the device under test that skips all storage. The fourth is a fixed idle code.

The waveform storage is two equal banks used as a ping-pong pair. One bank plays while the processor writes the other one. Processor writes are always steered to the bank that is not playing. A swap request is held pending until the play pointer wraps, so a loop that holds two periods of the analog signal is never cut in the middle. The stream memory has its own storage and its own write port. It shares the play pointer and the loop length with the waveform banks.

Top module: `wave_player`

## Requirements
- R1: While reset is asserted, `dac_cs_n` is 1, `dac_sclk` is 0 and `active_bank` is 0.
- R2: A frame starts one cycle after a conversion strobe. `dac_cs_n` stays 0 for exactly 16 rising edges of `dac_sclk`. `dac_sdo` carries the code most significant bit first and is stable across each rising edge. `dac_sclk` is 0 whenever `dac_cs_n` is 1.
- R3: Conversion strobes repeat every `rate_div`+1 clock cycles. A strobe that arrives while a frame is still being sent starts no frame.
- R4: With `run`=1 and `src_sel`=0, successive frames carry the active bank's words at addresses 0, 1, … `loop_last`, and then restart at address 0.
- R5: A processor write always lands in the bank that is not playing. The codes being played do not change.
- R6: While running, a `swap_req` pulse takes effect when the frame for address `loop_last` starts. `active_bank` toggles at that point, and the next frame reads address 0 of the other bank. While stopped, a pending swap takes effect within two cycles.
- R7: With `run`=1 and `src_sel`=1, frames carry the stream memory at the play pointer. Writes from the device under test never change the waveform banks.
- R8: With `run`=1 and `src_sel`=2, a frame carries the `bypass_data` value present in its strobe cycle.
- R9: With `run`=0, or with `src_sel`=3, frames carry `idle_code`. While `run`=0 the play pointer is held at address 0.
- R10: `loop_last` sets the last address played before the pointer wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | ADDR_W | Processor write address |
| cpu_wdata | input | SAMPLE_W | Processor write data |
| swap_req | input | 1 | Request to exchange the play and fill banks |
| dut_we | input | 1 | Stream memory write strobe |
| dut_addr | input | ADDR_W | Stream memory write address |
| dut_wdata | input | SAMPLE_W | Stream memory write data |
| bypass_data | input | SAMPLE_W | Direct code that skips storage |
| run | input | 1 | 1 = play, 0 = hold idle code |
| src_sel | input | 2 | 0 wave, 1 stream, 2 bypass, 3 idle |
| rate_div | input | DIV_W | Strobe period minus one, in clock cycles |
| loop_last | input | ADDR_W | Last address before the pointer wraps |
| idle_code | input | SAMPLE_W | Code sent while stopped |
| dac_cs_n | output | 1 | DAC frame select, active low |
| dac_sclk | output | 1 | DAC serial clock |
| dac_sdo | output | 1 | DAC serial data |
| active_bank | output | 1 | Index of the bank now playing |

## Verification
A strobe in cycle t drops `dac_cs_n` at t+1. Bit k rises on `dac_sclk` at t+2+2k, and `dac_cs_n` returns high at t+33. The code of each frame is fixed in its strobe cycle, so the bench changes sources, codes and swap requests only at the frame boundary the monitor sees. That boundary is at least seven cycles before the next strobe, and the expected codes are queued in playback order. `active_bank` is sampled at a frame end. Before the wrap frame starts it still shows the old bank, and one frame later it shows the new one. The strobe period is measured between successive falling edges of `dac_cs_n`, skipping the first frame after a rate change.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        SRC_WAVE   = 2'd0,
        SRC_STREAM = 2'd1,
        SRC_BYPASS = 2'd2,
        SRC_IDLE   = 2'd3
    } src_e;
endpackage

// File: rtl/wp_rate_gen.sv
module wp_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_div,
    output logic             strobe
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt = rate_div;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = (st_q.cnt == '0);
endmodule

// File: rtl/wp_wave_mem.sv
module wp_wave_mem #(
    parameter int ADDR_W   = 6,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [SAMPLE_W-1:0] cpu_wdata,
    input  logic                wr_bank,
    input  logic                rd_bank,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                dut_we,
    input  logic [ADDR_W-1:0]   dut_addr,
    input  logic [SAMPLE_W-1:0] dut_wdata,
    output logic [SAMPLE_W-1:0] wave_rd,
    output logic [SAMPLE_W-1:0] stream_rd
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NBANKS = 2;

    logic [SAMPLE_W-1:0] bank_rd [NBANKS];

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        logic [SAMPLE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (cpu_we && (wr_bank == 1'(g))) begin
                mem[cpu_addr] <= cpu_wdata;
            end
        end
        assign bank_rd[g] = mem[rd_addr];
    end

    logic [SAMPLE_W-1:0] smem [DEPTH];
    always_ff @(posedge clk) begin
        if (dut_we) begin
            smem[dut_addr] <= dut_wdata;
        end
    end

    assign wave_rd   = bank_rd[rd_bank];
    assign stream_rd = smem[rd_addr];
endmodule

// File: rtl/wp_spi_tx.sv
module wp_spi_tx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] data,
    output logic                busy,
    output logic                cs_n,
    output logic                sclk,
    output logic                sdo
);
    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic                act;
        logic                ph;
        logic [CNT_W-1:0]    bitn;
        logic [SAMPLE_W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.act) begin
            if (start) begin
                st_d.act  = 1'b1;
                st_d.ph   = 1'b0;
                st_d.bitn = '0;
                st_d.sh   = data;
            end
        end else if (!st_q.ph) begin
            st_d.ph = 1'b1;
        end else begin
            st_d.ph = 1'b0;
            if (st_q.bitn == LAST_BIT) begin
                st_d.act = 1'b0;
            end else begin
                st_d.bitn = st_q.bitn + 1'b1;
                st_d.sh   = {st_q.sh[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.act;
    assign cs_n = !st_q.act;
    assign sclk = st_q.ph;
    assign sdo  = st_q.sh[SAMPLE_W-1];
endmodule

// File: rtl/wave_player.sv
module wave_player #(
    parameter int ADDR_W   = 6,
    parameter int SAMPLE_W = 16,
    parameter int DIV_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [SAMPLE_W-1:0] cpu_wdata,
    input  logic                swap_req,
    input  logic                dut_we,
    input  logic [ADDR_W-1:0]   dut_addr,
    input  logic [SAMPLE_W-1:0] dut_wdata,
    input  logic [SAMPLE_W-1:0] bypass_data,
    input  logic                run,
    input  logic [1:0]          src_sel,
    input  logic [DIV_W-1:0]    rate_div,
    input  logic [ADDR_W-1:0]   loop_last,
    input  logic [SAMPLE_W-1:0] idle_code,
    output logic                dac_cs_n,
    output logic                dac_sclk,
    output logic                dac_sdo,
    output logic                active_bank
);
    import wp_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              active;
        logic              pend;
    } st_t;

    st_t st_d, st_q;

    logic                strobe;
    logic                tx_busy;
    logic                tx_go;
    logic [SAMPLE_W-1:0] wave_rd;
    logic [SAMPLE_W-1:0] stream_rd;
    logic [SAMPLE_W-1:0] sample;
    logic [ADDR_W-1:0]   play_ptr;
    src_e                src;

    assign src      = src_e'(src_sel);
    assign tx_go    = strobe && !tx_busy;
    assign play_ptr = st_q.ptr;

    wp_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_div (rate_div),
        .strobe   (strobe)
    );

    wp_wave_mem #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_mem (
        .clk       (clk),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .wr_bank   (!st_q.active),
        .rd_bank   (st_q.active),
        .rd_addr   (st_q.ptr),
        .dut_we    (dut_we),
        .dut_addr  (dut_addr),
        .dut_wdata (dut_wdata),
        .wave_rd   (wave_rd),
        .stream_rd (stream_rd)
    );

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.ptr = '0;
            if (st_q.pend) begin
                st_d.active = !st_q.active;
                st_d.pend   = 1'b0;
            end
        end else if (tx_go) begin
            if (st_q.ptr >= loop_last) begin
                st_d.ptr = '0;
                if (st_q.pend) begin
                    st_d.active = !st_q.active;
                    st_d.pend   = 1'b0;
                end
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        if (swap_req) begin
            st_d.pend = 1'b1;
        end
    end

    always_comb begin
        if (!run) begin
            sample = idle_code;
        end else begin
            unique case (src)
                SRC_WAVE:   sample = wave_rd;
                SRC_STREAM: sample = stream_rd;
                SRC_BYPASS: sample = bypass_data;
                default:    sample = idle_code;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wp_spi_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_go),
        .data  (sample),
        .busy  (tx_busy),
        .cs_n  (dac_cs_n),
        .sclk  (dac_sclk),
        .sdo   (dac_sdo)
    );

    assign active_bank = st_q.active;
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [DIV_W-1:0]  rate_div,
    input logic [ADDR_W-1:0] loop_last,
    input logic              strobe,
    input logic              tx_go,
    input logic [ADDR_W-1:0] play_ptr,
    input logic              active_bank,
    input logic              dac_cs_n,
    input logic              dac_sclk
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk); // R2

    AST_FRAME_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> $past(strobe)); // R2

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rate_div != '0) |=> !strobe); // R3

    AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_bank != $past(active_bank)) && $past(run))
            |-> ($past(tx_go) && ($past(play_ptr) >= $past(loop_last)))); // R6

    AST_STOP_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (play_ptr == '0)); // R9
endmodule

bind wave_player wp_checker #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .rate_div    (rate_div),
    .loop_last   (loop_last),
    .strobe      (strobe),
    .tx_go       (tx_go),
    .play_ptr    (play_ptr),
    .active_bank (active_bank),
    .dac_cs_n    (dac_cs_n),
    .dac_sclk    (dac_sclk)
);

// File: tb/test_wave_player.sv
module test_wave_player;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int SW = 16;
    localparam int DIV_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [SW-1:0] cpu_wdata = '0;
    logic swap_req = 1'b0;
    logic dut_we = 1'b0;
    logic [ADDR_W-1:0] dut_addr = '0;
    logic [SW-1:0] dut_wdata = '0;
    logic [SW-1:0] bypass_data = '0;
    logic run = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [DIV_W-1:0] rate_div = 16'd39;
    logic [ADDR_W-1:0] loop_last = 6'd3;
    logic [SW-1:0] idle_code = 16'h8000;
    logic dac_cs_n, dac_sclk, dac_sdo, active_bank;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_player #(.ADDR_W(ADDR_W), .SAMPLE_W(SW), .DIV_W(DIV_W)) i_wave_player (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .swap_req(swap_req),
        .dut_we(dut_we), .dut_addr(dut_addr), .dut_wdata(dut_wdata),
        .bypass_data(bypass_data), .run(run), .src_sel(src_sel),
        .rate_div(rate_div), .loop_last(loop_last), .idle_code(idle_code),
        .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
        .active_bank(active_bank)
    );

    int n_vec = 0;
    int n_bad = 0;
    int frames = 0;
    int pending = 0;
    int cyc = 0;
    int last_fall = 0;
    int period = 0;
    logic [SW-1:0] exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: decodes each frame and compares it against the scoreboard
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b0;
    logic [SW-1:0] word = '0;
    int nbits = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !dac_cs_n) begin
                period = cyc - last_fall;
                last_fall = cyc;
                word = '0;
                nbits = 0;
            end
            if (!dac_cs_n && !prev_sclk && dac_sclk) begin
                word = {word[SW-2:0], dac_sdo};
                nbits++;
            end
            if (!prev_cs && dac_cs_n) begin
                if (pending > 0) begin
                    logic [SW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(word == e, t, int'(word), int'(e));
                    check(nbits == SW, "R2 bit count", nbits, SW);
                    pending--;
                end
                frames++;
            end
        end
        prev_cs = dac_cs_n;
        prev_sclk = dac_sclk;
    end

    task automatic push(input logic [SW-1:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
        pending++;
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    task automatic frame_end();
        int f;
        f = frames;
        wait (frames != f);
    endtask

    task automatic cpu_wr(input int a, input logic [SW-1:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = ADDR_W'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic dut_wr(input int a, input logic [SW-1:0] d);
        @(negedge clk);
        dut_we = 1'b1; dut_addr = ADDR_W'(a); dut_wdata = d;
        @(negedge clk);
        dut_we = 1'b0;
    endtask

    task automatic pulse_swap();
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
    endtask

    logic [SW-1:0] wa [4] = '{16'hA001, 16'hA002, 16'hA003, 16'hA004};
    logic [SW-1:0] wb [4] = '{16'hB010, 16'hB020, 16'hB030, 16'hB040};
    logic [SW-1:0] wc [4] = '{16'hC100, 16'hC200, 16'hC300, 16'hC400};
    logic [SW-1:0] wd [4] = '{16'h0D01, 16'h1D02, 16'h2D03, 16'h3D04};

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check(dac_cs_n == 1'b1, "R1 cs_n in reset", int'(dac_cs_n), 1);
        check(dac_sclk == 1'b0, "R1 sclk in reset", int'(dac_sclk), 0);
        check(active_bank == 1'b0, "R1 bank in reset", int'(active_bank), 0);
        rst_n = 1'b1;

        // stopped: idle code
        frame_end();
        push(16'h8000, "R9 stopped idle"); push(16'h8000, "R9 stopped idle");
        drain();

        // fill bank 1 (inactive), swap while stopped, fill bank 0
        for (int i = 0; i < 4; i++) cpu_wr(i, wa[i]);
        pulse_swap();
        repeat (3) @(negedge clk);
        check(active_bank == 1'b1, "R6 stopped swap", int'(active_bank), 1);
        for (int i = 0; i < 4; i++) cpu_wr(i, wb[i]);
        frame_end();

        // play bank 1
        run = 1'b1; src_sel = 2'd0;
        for (int i = 0; i < 4; i++) push(wa[i], "R4 loop bank A");
        push(wa[0], "R4 wrap to 0"); push(wa[1], "R4 wrap to 0");
        drain();
        check(period == 40, "R3 period 40", period, 40);

        // swap while running, takes effect at wrap
        pulse_swap();
        push(wa[2], "R6 before wrap");
        drain();
        check(active_bank == 1'b1, "R6 bank held until wrap", int'(active_bank), 1);
        push(wa[3], "R6 wrap frame"); push(wb[0], "R6 new bank");
        drain();
        check(active_bank == 1'b0, "R6 bank after wrap", int'(active_bank), 0);

        // write during playback lands in idle bank
        push(wb[1], "R5 play unaffected"); push(wb[2], "R5 play unaffected");
        for (int i = 0; i < 4; i++) cpu_wr(i, wc[i]);
        drain();
        pulse_swap();
        push(wb[3], "R5 play unaffected"); push(wc[0], "R5 write went to idle bank");
        push(wc[1], "R5 write went to idle bank");
        drain();

        // stop then shorter loop
        run = 1'b0;
        push(16'h8000, "R9 stop");
        drain();
        loop_last = 6'd1; run = 1'b1;
        push(wc[0], "R10 short loop"); push(wc[1], "R10 short loop");
        push(wc[0], "R10 short loop wrap");
        drain();
        run = 1'b0;
        push(16'h8000, "R9 stop");
        drain();

        // DUT stream memory
        for (int i = 0; i < 4; i++) dut_wr(i, wd[i]);
        frame_end();
        loop_last = 6'd3; src_sel = 2'd1; run = 1'b1;
        for (int i = 0; i < 4; i++) push(wd[i], "R7 stream");
        push(wd[0], "R7 stream wrap");
        drain();
        run = 1'b0;
        push(16'h8000, "R9 stop");
        drain();
        src_sel = 2'd0; run = 1'b1;
        for (int i = 0; i < 4; i++) push(wc[i], "R7 banks untouched");
        drain();

        // bypass
        src_sel = 2'd2; bypass_data = 16'h1234;
        push(16'h1234, "R8 bypass");
        drain();
        bypass_data = 16'hABCD;
        push(16'hABCD, "R8 bypass new value");
        drain();

        // idle source while running, new idle code
        src_sel = 2'd3; idle_code = 16'h4321;
        push(16'h4321, "R9 idle source");
        drain();

        // slower rate
        rate_div = 16'd49;
        push(16'h4321, "R3 rate change");
        drain();
        push(16'h4321, "R3 rate 50"); push(16'h4321, "R3 rate 50");
        drain();
        check(period == 50, "R3 period 50", period, 50);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule